// File: doc/BRIEF.md
# FPU register high-half transfer unit

This block moves the upper 32-bit word of a floating-point register to or from a general-purpose register. It holds the 32-entry floating-point register storage. It decodes the two transfer instructions from the instruction word it is given. A transfer towards the integer side returns a sign-extended 64-bit value with a one-cycle write strobe, which the pipeline uses to update its own integer register. A transfer towards the floating-point side updates the storage inside the block.

The block has two register-width modes. In wide mode every floating-point register is 64 bits, and the transfer touches its upper half. In paired mode two 32-bit registers make up one 64-bit value, so the "high half" of an even register is the low word of the next odd register. An odd register number in paired mode has no high half. Such a request does not trap: a read returns a fixed poison value, a write stores a different poison value, and a one-cycle warning flag is raised. When the floating-point unit is disabled, a decoded transfer raises a coprocessor-unusable pulse and changes no state.

Top module: `fhx_unit`

## Requirements
- R1: An instruction is a transfer only if bits 31:26 are 010001, bits 10:0 are all zero and bits 25:21 are 00011 (read high half) or 00111 (write high half). The register number is taken from bits 15:11. Any other word presented with `insn_vld` produces no output pulse and changes no register.
- R2: In wide mode (`fr64`=1), a read of register n sets `gpr_we` for exactly one cycle, one clock after issue. In that cycle `gpr_wdata` is bits 63:32 of register n, sign-extended to 64 bits.
- R3: In wide mode, a write to register n replaces its bits 63:32 with `gpr_src[31:0]`, keeps its bits 31:0, and does not raise `gpr_we`.
- R4: In paired mode (`fr64`=0), a read of an even register n returns bits 31:0 of register n+1, sign-extended to 64 bits, with the timing of R2.
- R5: In paired mode, a write to an even register n stores `gpr_src[31:0]` into bits 31:0 of register n+1 and keeps bits 63:32 of that register.
- R6: In paired mode, a read of an odd register returns the constant 0x0BADF00D sign-extended to 64 bits, with `gpr_we` set.
- R7: In paired mode, a write to an odd register n stores 0xDEADC0DE into bits 31:0 of register n.
- R8: `odd_warn` pulses for one cycle, one clock after issue, for each enabled paired-mode transfer to an odd register, in either direction. It stays low in wide mode and for even registers.
- R9: A decoded transfer issued with `fpu_en`=0 pulses `cop_unusable` for one cycle, one clock after issue. It raises neither `gpr_we` nor `odd_warn` and changes no register.
- R10: After reset all outputs are low and every floating-point register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_vld | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| gpr_src | input | 64 | Source general-register value for writes |
| fpu_en | input | 1 | Floating-point unit enabled |
| fr64 | input | 1 | 1 = 64-bit registers, 0 = paired 32-bit registers |
| gpr_wdata | output | 64 | Value to write into the general register |
| gpr_we | output | 1 | General-register write strobe |
| cop_unusable | output | 1 | Transfer attempted with the FPU disabled |
| odd_warn | output | 1 | Paired-mode transfer named an odd register |

## Verification
The bench switches modes on the same registers, because mixing modes is the only way to see through the ports which half a write touched. A design that wrote the wrong half, or cleared the kept half, returns a stale or zero word on the later cross-mode read. Odd registers in paired mode are tested in both directions. A design that traps, or that forwards to n+1, misses the poison value and the warning. A disabled transfer is followed by a read of the same register, which exposes a design that still updates storage. Words with a non-zero low field or a wrong selector field must cause no pulse and no later change in what is read back.

// File: rtl/fhx_pkg.sv
package fhx_pkg;
  localparam logic [5:0] FHX_OPC   = 6'b010001;
  localparam logic [4:0] FHX_SEL_R = 5'b00011;
  localparam logic [4:0] FHX_SEL_W = 5'b00111;
  localparam logic [31:0] FHX_POISON_RD = 32'h0BADF00D;
  localparam logic [31:0] FHX_POISON_WR = 32'hDEADC0DE;

  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_RD   = 2'd1,
    XF_WR   = 2'd2
  } xf_op_e;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/fhx_decode.sv
module fhx_decode
  import fhx_pkg::*;
#(
  parameter int IW = 32,
  parameter int AW = 5
) (
  input  logic [IW-1:0] insn,
  output xf_op_e        op,
  output logic [AW-1:0] fs
);
  logic opc_ok;
  logic tail_ok;

  always_comb begin
    opc_ok  = (insn[31:26] == FHX_OPC);
    tail_ok = (insn[10:0] == 11'd0);
    fs      = insn[11 +: AW];
    op      = XF_NONE;
    if (opc_ok && tail_ok) begin
      if (insn[25:21] == FHX_SEL_R)      op = XF_RD;
      else if (insn[25:21] == FHX_SEL_W) op = XF_WR;
    end
  end
endmodule

// File: rtl/fhx_regfile.sv
module fhx_regfile #(
  parameter int NREG = 32,
  parameter int HW   = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [AW-1:0] wr_addr,
  input  logic [HW-1:0] wr_word,
  input  logic [AW-1:0] rd_addr,
  output logic [HW-1:0] rd_hi,
  output logic [HW-1:0] rd_lo
);
  logic [HW-1:0] hi_q [NREG];
  logic [HW-1:0] lo_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic sel;
    logic hi_ce;
    logic lo_ce;

    always_comb begin
      sel   = wr_en && (wr_addr == AW'(g));
      hi_ce = sel && wr_hi;
      lo_ce = sel && !wr_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_q[g] <= '0;
      else if (hi_ce) hi_q[g] <= wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_q[g] <= '0;
      else if (lo_ce) lo_q[g] <= wr_word;
    end
  end

  always_comb begin
    rd_hi = hi_q[rd_addr];
    rd_lo = lo_q[rd_addr];
  end
endmodule

// File: rtl/fhx_xfer.sv
module fhx_xfer
  import fhx_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HW   = 32,
  parameter int AW   = 5,
  parameter logic [HW-1:0] POISON_RD = FHX_POISON_RD[HW-1:0],
  parameter logic [HW-1:0] POISON_WR = FHX_POISON_WR[HW-1:0]
) (
  input  logic            vld,
  input  xf_op_e          op,
  input  logic [AW-1:0]   fs,
  input  logic            fpu_en,
  input  logic            fr64,
  input  logic [XLEN-1:0] src,
  output logic [AW-1:0]   rd_addr,
  input  logic [HW-1:0]   rd_hi,
  input  logic [HW-1:0]   rd_lo,
  output logic            rf_wr,
  output logic            rf_hi,
  output logic [AW-1:0]   rf_addr,
  output logic [HW-1:0]   rf_word,
  output logic            nxt_we,
  output logic [XLEN-1:0] nxt_data,
  output logic            nxt_cop,
  output logic            nxt_warn
);
  localparam int EXT = XLEN - HW;

  logic          hit;
  logic          go;
  logic          odd_pair;
  logic [AW-1:0] partner;
  logic [HW-1:0] word;

  always_comb begin
    hit      = vld && (op != XF_NONE);
    go       = hit && fpu_en;
    odd_pair = !fr64 && fs[0];
    partner  = fs | AW'(1);

    rd_addr  = fr64 ? fs : partner;
    if (fr64)          word = rd_hi;
    else if (odd_pair) word = POISON_RD;
    else               word = rd_lo;

    rf_wr   = go && (op == XF_WR);
    rf_hi   = fr64 ? HALF_HI : HALF_LO;
    rf_addr = fr64 ? fs : (odd_pair ? fs : partner);
    rf_word = odd_pair ? POISON_WR : src[HW-1:0];

    nxt_we   = go && (op == XF_RD);
    nxt_data = nxt_we ? {{EXT{word[HW-1]}}, word} : '0;
    nxt_cop  = hit && !fpu_en;
    nxt_warn = go && odd_pair;
  end
endmodule

// File: rtl/fhx_unit.sv
module fhx_unit
  import fhx_pkg::*;
#(
  parameter int NREG = 32,
  parameter int XLEN = 64,
  parameter int IW   = 32,
  localparam int HW  = XLEN / 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_vld,
  input  logic [IW-1:0]   insn,
  input  logic [XLEN-1:0] gpr_src,
  input  logic            fpu_en,
  input  logic            fr64,
  output logic [XLEN-1:0] gpr_wdata,
  output logic            gpr_we,
  output logic            cop_unusable,
  output logic            odd_warn
);
  xf_op_e          op;
  logic [AW-1:0]   fs;
  logic [AW-1:0]   rd_addr;
  logic [HW-1:0]   rd_hi;
  logic [HW-1:0]   rd_lo;
  logic            rf_wr;
  logic            rf_hi;
  logic [AW-1:0]   rf_addr;
  logic [HW-1:0]   rf_word;
  logic            nxt_we;
  logic [XLEN-1:0] nxt_data;
  logic            nxt_cop;
  logic            nxt_warn;
  logic            data_ce;

  fhx_decode #(.IW(IW), .AW(AW)) u_dec (
    .insn (insn),
    .op   (op),
    .fs   (fs)
  );

  fhx_xfer #(.XLEN(XLEN), .HW(HW), .AW(AW)) u_xfer (
    .vld      (insn_vld),
    .op       (op),
    .fs       (fs),
    .fpu_en   (fpu_en),
    .fr64     (fr64),
    .src      (gpr_src),
    .rd_addr  (rd_addr),
    .rd_hi    (rd_hi),
    .rd_lo    (rd_lo),
    .rf_wr    (rf_wr),
    .rf_hi    (rf_hi),
    .rf_addr  (rf_addr),
    .rf_word  (rf_word),
    .nxt_we   (nxt_we),
    .nxt_data (nxt_data),
    .nxt_cop  (nxt_cop),
    .nxt_warn (nxt_warn)
  );

  fhx_regfile #(.NREG(NREG), .HW(HW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rf_wr),
    .wr_hi   (rf_hi),
    .wr_addr (rf_addr),
    .wr_word (rf_word),
    .rd_addr (rd_addr),
    .rd_hi   (rd_hi),
    .rd_lo   (rd_lo)
  );

  always_comb data_ce = nxt_we || gpr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpr_we       <= 1'b0;
      cop_unusable <= 1'b0;
      odd_warn     <= 1'b0;
    end else begin
      gpr_we       <= nxt_we;
      cop_unusable <= nxt_cop;
      odd_warn     <= nxt_warn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gpr_wdata <= '0;
    else if (data_ce) gpr_wdata <= nxt_data;
  end
endmodule

// File: rtl/fhx_unit_chk.sv
module fhx_unit_chk #(
  parameter int XLEN = 64,
  parameter int IW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_vld,
  input logic [IW-1:0]   insn,
  input logic            fpu_en,
  input logic            fr64,
  input logic [XLEN-1:0] gpr_wdata,
  input logic            gpr_we,
  input logic            cop_unusable,
  input logic            odd_warn
);
  localparam int HW = XLEN / 2;

  logic is_rd;
  logic is_wr;
  always_comb begin
    is_rd = (insn[31:26] == 6'b010001) && (insn[25:21] == 5'b00011) && (insn[10:0] == 11'd0);
    is_wr = (insn[31:26] == 6'b010001) && (insn[25:21] == 5'b00111) && (insn[10:0] == 11'd0);
  end

  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_vld |=> (!gpr_we && !cop_unusable && !odd_warn));

  a_r2_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we |-> (gpr_wdata[XLEN-1:HW] == {HW{gpr_wdata[HW-1]}}));

  a_r2_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && is_rd && fpu_en) |=> (gpr_we && !cop_unusable));

  a_r3_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && is_wr) |=> !gpr_we);

  a_r6_poison: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && is_rd && fpu_en && !fr64 && insn[11]) |=>
      (gpr_we && gpr_wdata == 64'h0000_0000_0BAD_F00D));

  a_r8_warn_cause: assert property (@(posedge clk) disable iff (!rst_n)
    odd_warn |-> $past(insn_vld && (is_rd || is_wr) && fpu_en && !fr64 && insn[11]));

  a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_vld && (is_rd || is_wr) && !fpu_en) |=> (cop_unusable && !gpr_we && !odd_warn));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gpr_we, cop_unusable}));
endmodule

bind fhx_unit fhx_unit_chk #(.XLEN(XLEN), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .insn_vld     (insn_vld),
  .insn         (insn),
  .fpu_en       (fpu_en),
  .fr64         (fr64),
  .gpr_wdata    (gpr_wdata),
  .gpr_we       (gpr_we),
  .cop_unusable (cop_unusable),
  .odd_warn     (odd_warn)
);

// File: tb/fhx_unit_bench.sv
module fhx_unit_bench;
  logic        clk;
  logic        rst_n;
  logic        insn_vld;
  logic [31:0] insn;
  logic [63:0] gpr_src;
  logic        fpu_en;
  logic        fr64;
  logic [63:0] gpr_wdata;
  logic        gpr_we;
  logic        cop_unusable;
  logic        odd_warn;

  int total;
  int bad;
  logic [63:0] mdl [32];

  fhx_unit u_fhx_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_vld     (insn_vld),
    .insn         (insn),
    .gpr_src      (gpr_src),
    .fpu_en       (fpu_en),
    .fr64         (fr64),
    .gpr_wdata    (gpr_wdata),
    .gpr_we       (gpr_we),
    .cop_unusable (cop_unusable),
    .odd_warn     (odd_warn)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input bit wr, input logic [4:0] fs);
    return {6'b010001, (wr ? 5'b00111 : 5'b00011), 5'd2, fs, 11'd0};
  endfunction

  function automatic logic [63:0] sx(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  // Issue one word for one cycle, sample outputs the next negedge.
  task automatic issue_raw(input logic [31:0] w, input logic [63:0] src, input bit en, input bit fr,
                           input bit ewe, input logic [63:0] edata, input bit ecop, input bit ewarn,
                           input string tag);
    @(negedge clk);
    insn_vld = 1'b1; insn = w; gpr_src = src; fpu_en = en; fr64 = fr;
    @(negedge clk);
    insn_vld = 1'b0; insn = '0;
    chk(gpr_we == ewe, {tag, " we"}, 64'(gpr_we), 64'(ewe));
    if (ewe) chk(gpr_wdata == edata, {tag, " data"}, gpr_wdata, edata);
    chk(cop_unusable == ecop, {tag, " cop"}, 64'(cop_unusable), 64'(ecop));
    chk(odd_warn == ewarn, {tag, " warn"}, 64'(odd_warn), 64'(ewarn));
  endtask

  // Well-formed transfer: expected values from the bench model.
  task automatic xfer(input bit wr, input logic [4:0] fs, input logic [63:0] src,
                      input bit en, input bit fr, input string tag);
    logic [63:0] ed;
    bit odd;
    odd = !fr && fs[0];
    ed  = '0;
    if (!wr) begin
      if (fr)       ed = sx(mdl[fs][63:32]);
      else if (odd) ed = sx(32'h0BADF00D);
      else          ed = sx(mdl[fs | 5'd1][31:0]);
    end
    issue_raw(enc(wr, fs), src, en, fr, en && !wr, ed, !en, en && odd, tag);
    if (wr && en) begin
      if (fr)       mdl[fs][63:32] = src[31:0];
      else if (odd) mdl[fs][31:0] = 32'hDEADC0DE;
      else          mdl[fs | 5'd1][31:0] = src[31:0];
    end
  endtask

  task automatic t_reset;
    chk(!gpr_we && !cop_unusable && !odd_warn, "R10 outputs after reset",
        64'({gpr_we, cop_unusable, odd_warn}), 64'd0);
    xfer(1'b0, 5'd5, '0, 1'b1, 1'b1, "R10 wide read zero");
    xfer(1'b0, 5'd8, '0, 1'b1, 1'b0, "R10 paired read zero");
  endtask

  task automatic t_wide;
    xfer(1'b1, 5'd3, 64'h1111_2222_8000_1234, 1'b1, 1'b1, "R3 wide write neg");
    xfer(1'b0, 5'd3, '0, 1'b1, 1'b1, "R2 wide read neg");
    xfer(1'b1, 5'd31, 64'h0, 1'b1, 1'b1, "R3 wide write top reg");
    xfer(1'b1, 5'd31, 64'hFFFF_FFFF_7ABC_DEF0, 1'b1, 1'b1, "R3 wide write pos");
    xfer(1'b0, 5'd31, '0, 1'b1, 1'b1, "R2 wide read pos");
    xfer(1'b0, 5'd3, '0, 1'b1, 1'b1, "R8 wide odd no warn");
    xfer(1'b0, 5'd2, '0, 1'b1, 1'b0, "R3 low half kept");
  endtask

  task automatic t_pair_even;
    xfer(1'b1, 5'd2, 64'h5555_5555_CAFE_F00D, 1'b1, 1'b0, "R5 paired write even");
    xfer(1'b0, 5'd2, '0, 1'b1, 1'b0, "R4 paired read even");
    xfer(1'b0, 5'd3, '0, 1'b1, 1'b1, "R5 upper half kept");
    xfer(1'b0, 5'd2, '0, 1'b1, 1'b1, "R5 even reg untouched");
    xfer(1'b1, 5'd30, 64'h0000_0000_1234_5678, 1'b1, 1'b0, "R5 paired write 30");
    xfer(1'b0, 5'd30, '0, 1'b1, 1'b0, "R4 paired read 30");
  endtask

  task automatic t_pair_odd;
    xfer(1'b0, 5'd7, '0, 1'b1, 1'b0, "R6 R8 odd read poison");
    xfer(1'b1, 5'd7, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, "R7 R8 odd write poison");
    xfer(1'b0, 5'd6, '0, 1'b1, 1'b0, "R7 poison stored");
    xfer(1'b0, 5'd8, '0, 1'b1, 1'b0, "R7 neighbour untouched");
    xfer(1'b0, 5'd7, '0, 1'b1, 1'b1, "R7 upper of odd kept");
  endtask

  task automatic t_disabled;
    xfer(1'b1, 5'd3, 64'h0000_0000_DDDD_EEEE, 1'b0, 1'b1, "R9 wide write disabled");
    xfer(1'b1, 5'd2, 64'h0000_0000_DDDD_EEEE, 1'b0, 1'b0, "R9 paired write disabled");
    xfer(1'b1, 5'd9, 64'h0, 1'b0, 1'b0, "R9 odd write disabled");
    xfer(1'b0, 5'd3, '0, 1'b0, 1'b1, "R9 read disabled");
    xfer(1'b0, 5'd3, '0, 1'b1, 1'b1, "R9 wide state kept");
    xfer(1'b0, 5'd2, '0, 1'b1, 1'b0, "R9 paired state kept");
    xfer(1'b0, 5'd8, '0, 1'b1, 1'b0, "R9 odd target kept");
  endtask

  task automatic t_illegal;
    issue_raw(enc(1'b1, 5'd3) | 32'h1, 64'h0000_0000_ABAB_ABAB, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R1 low field set");
    issue_raw({6'b010001, 5'b00100, 5'd0, 5'd3, 11'd0}, 64'h0000_0000_ABAB_ABAB, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R1 other selector");
    issue_raw({6'b010000, 5'b00111, 5'd0, 5'd3, 11'd0}, 64'h0000_0000_ABAB_ABAB, 1'b1, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R1 other opcode");
    issue_raw({6'b010000, 5'b00011, 5'd0, 5'd3, 11'd0}, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R1 no cop on foreign");
    xfer(1'b0, 5'd3, '0, 1'b1, 1'b1, "R1 state unchanged");
  endtask

  initial begin
    total = 0; bad = 0;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    insn_vld = 1'b0; insn = '0; gpr_src = '0; fpu_en = 1'b0; fr64 = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_wide;
    t_pair_even;
    t_pair_odd;
    t_disabled;
    t_illegal;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule